// File: doc/BRIEF.md
# BCD Clock-Calendar Counter Chain

This block holds the time of day and the date as packed BCD digits: seconds, minutes, hours, day of month, month, a two-digit year and a day-of-week count. A one-cycle `tick_i` pulse advances it by one second. Carries ripple through the chain in the same clock edge. The chain supports a 12-hour mode with an AM/PM flag and a 24-hour mode. It has automatic leap years and corrects a written date that does not exist.

Software reaches each digit as a 4-bit register at its own address. It can write any digit while the clock runs. A hold input freezes counting during multi-digit access without losing a second. A rounding request snaps the seconds to the nearest minute after a fixed delay. One-cycle strobes report each applied second, each minute advance and each hour advance, so the logic around the block can derive periodic events from them.

Top module: `bcd_calendar`

## Requirements
- R1: After reset all digits read 0 except day-ones (address 6) and month-ones (address 8), which read 1. The date is day 01 of month 01, year 00, day of week 0. The time is 00:00:00. All strobes and `adj_busy_o` are low.
- R2: Each applied tick adds one second. Seconds and minutes count 00 to 59 in BCD. Seconds wrap from 59 to 00 with a carry into minutes.
- R3: In 24-hour mode (`mode24_i`=1) hours count 00 to 23. A minute carry at 23:59 wraps the hours to 00 and advances the day.
- R4: In 12-hour mode, bit 2 of address 5 is the PM flag (1 = PM). The hour sequence is 12, 1 … 11 AM, then 12, 1 … 11 PM. The flag toggles at 11 to 12, and the day advances at 11 PM to 12 AM.
- R5: The month lengths are 31, 28/29, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 days. February has 29 days when the two-digit year is a multiple of 4, across the whole range 00 to 99.
- R6: On a day carry, a day value at or past the month's last day becomes day 01 of the next month. A written Feb 29 of a non-leap year therefore becomes Mar 1, and Nov 31 becomes Dec 1.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00. The day of week advances on every day carry and wraps from 6 to 0.
- R8: The digit addresses are: 0 and 1 seconds (ones, tens), 2 and 3 minutes, 4 and 5 hours, 6 and 7 day, 8 and 9 month, A and B year, C day of week. Nonexistent bits ignore writes and read 0: bit 3 of addresses 1, 3 and C; bit 3 of address 5 (and bit 2 in 24-hour mode); bits 3:2 of address 7; bits 3:1 of address 9. Addresses D to F read 0.
- R9: In 24-hour mode the PM flag reads 0, and a write to address 5 leaves it unchanged.
- R10: While `hold_i` is high no second is applied. Any tick during hold is remembered, and exactly one second is added in the cycle after hold falls. Several held ticks collapse into one.
- R11: A pulse on `adj_req_i` raises `adj_busy_o` for exactly ADJ_CYCLES cycles, and a request during that window is ignored. When busy falls, seconds 00–29 have become 00, and seconds 30–59 have become 00 with a minute carry that may ripple further. No second strobe is produced.
- R12: `sec_carry_o`, `min_carry_o` and `hour_carry_o` pulse for one cycle, in the cycle the new digit values first appear. An hour strobe always comes with a minute strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode24_i | input | 1 | 1 selects 24-hour mode, 0 selects 12-hour mode |
| tick_i | input | 1 | One-second advance pulse |
| hold_i | input | 1 | Suppresses advancing; a held tick is applied on release |
| adj_req_i | input | 1 | Requests a 30-second rounding adjust |
| wr_en_i | input | 1 | Digit write strobe |
| wr_addr_i | input | 4 | Digit address for a write |
| wr_data_i | input | 4 | Write data |
| rd_addr_i | input | 4 | Digit address for a read |
| rd_data_o | output | 4 | Read data for `rd_addr_i` (combinational) |
| adj_busy_o | output | 1 | Rounding adjust in progress |
| sec_carry_o | output | 1 | A second was applied |
| min_carry_o | output | 1 | Minutes advanced |
| hour_carry_o | output | 1 | Hours advanced |

## Verification
A wrong month-length or leap decision stays hidden until the last day of a month rolls over. It then shows at the day and month addresses in the very cycle after the tick, so the bench steps the rollover of every day 28 to 31 in every month of every year 00–99. A wrong hour decode appears at the hour boundary as a missing PM toggle or a premature day carry. A lost held tick or a wrong adjust length appears as a seconds digit one off, or as busy falling one cycle early or late. The bench reads every digit after every step, so a fault in one counter is reported in the same step.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int ADJ_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode24_i,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       adj_req_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [3:0] wr_data_i,
  input  logic [3:0] rd_addr_i,
  output logic [3:0] rd_data_o,
  output logic       adj_busy_o,
  output logic       sec_carry_o,
  output logic       min_carry_o,
  output logic       hour_carry_o
);
  localparam int CW = $clog2(ADJ_CYCLES) + 1;

  logic [3:0] s1, m1, h1, d1, mo1, y1, y10;
  logic [2:0] s10, m10, wd;
  logic [1:0] h10, d10;
  logic       mo10, pm, pend, busy;
  logic [CW-1:0] cnt;
  logic       sec_q, min_q, hr_q;
  logic [5:0] day_b, dim;
  logic [4:0] mo_b;
  logic [7:0] yr_b;

  wire fire    = busy && (cnt == CW'(ADJ_CYCLES - 1));
  wire do_sec  = !hold_i && (tick_i || pend) && !fire;
  wire s_last  = (s1 >= 4'd9) && (s10 >= 3'd5);
  wire m_last  = (m1 >= 4'd9) && (m10 >= 3'd5);
  wire adj_up  = fire && (s10 >= 3'd3);
  wire min_inc = (do_sec && s_last) || adj_up;
  wire hr_inc  = min_inc && m_last;
  wire h_last  = mode24_i ? (h10 == 2'd2 && h1 >= 4'd3)
                          : (h10 == 2'd1 && h1 == 4'd1 && pm);
  wire day_inc = hr_inc && h_last;

  assign day_b = {4'b0, d10} * 6'd10 + {2'b0, d1};
  assign mo_b  = mo10 ? 5'd10 + {1'b0, mo1} : {1'b0, mo1};
  assign yr_b  = {4'b0, y10} * 8'd10 + {4'b0, y1};
  wire leap    = (yr_b[1:0] == 2'd0);

  always_comb begin
    case (mo_b)
      5'd2:                       dim = leap ? 6'd29 : 6'd28;
      5'd4, 5'd6, 5'd9, 5'd11:    dim = 6'd30;
      default:                    dim = 6'd31;
    endcase
  end

  wire mo_inc = day_inc && (day_b >= dim);
  wire yr_inc = mo_inc && (mo_b >= 5'd12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s10 <= '0; m1 <= '0; m10 <= '0;
      h1 <= '0; h10 <= '0; pm <= 1'b0;
      d1 <= 4'd1; d10 <= '0; mo1 <= 4'd1; mo10 <= 1'b0;
      y1 <= '0; y10 <= '0; wd <= '0;
      pend <= 1'b0; busy <= 1'b0; cnt <= '0;
      sec_q <= 1'b0; min_q <= 1'b0; hr_q <= 1'b0;
    end else begin
      pend  <= (pend || tick_i) && !do_sec;
      sec_q <= do_sec;
      min_q <= min_inc;
      hr_q  <= hr_inc;

      if (fire) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
      end else if (adj_req_i) begin
        busy <= 1'b1;
        cnt  <= '0;
      end

      if (fire) begin
        s1 <= '0; s10 <= '0;
      end else if (do_sec) begin
        if (s_last) begin
          s1 <= '0; s10 <= '0;
        end else if (s1 >= 4'd9) begin
          s1 <= '0; s10 <= s10 + 3'd1;
        end else s1 <= s1 + 4'd1;
      end

      if (min_inc) begin
        if (m_last) begin
          m1 <= '0; m10 <= '0;
        end else if (m1 >= 4'd9) begin
          m1 <= '0; m10 <= m10 + 3'd1;
        end else m1 <= m1 + 4'd1;
      end

      if (hr_inc) begin
        if (mode24_i) begin
          if (h_last) begin
            h1 <= '0; h10 <= '0;
          end else if (h1 >= 4'd9) begin
            h1 <= '0; h10 <= h10 + 2'd1;
          end else h1 <= h1 + 4'd1;
        end else begin
          if (h10 == 2'd1 && h1 == 4'd2) begin
            h10 <= '0; h1 <= 4'd1;
          end else if (h10 == 2'd1 && h1 == 4'd1) begin
            h1 <= 4'd2; pm <= !pm;
          end else if (h1 >= 4'd9) begin
            h1 <= '0; h10 <= h10 + 2'd1;
          end else h1 <= h1 + 4'd1;
        end
      end

      if (day_inc) begin
        wd <= (wd >= 3'd6) ? 3'd0 : wd + 3'd1;
        if (mo_inc) begin
          d1 <= 4'd1; d10 <= '0;
        end else if (d1 >= 4'd9) begin
          d1 <= '0; d10 <= d10 + 2'd1;
        end else d1 <= d1 + 4'd1;
      end

      if (mo_inc) begin
        if (yr_inc) begin
          mo1 <= 4'd1; mo10 <= 1'b0;
        end else if (mo1 >= 4'd9) begin
          mo1 <= '0; mo10 <= 1'b1;
        end else mo1 <= mo1 + 4'd1;
      end

      if (yr_inc) begin
        if (y1 >= 4'd9) begin
          y1  <= '0;
          y10 <= (y10 >= 4'd9) ? 4'd0 : y10 + 4'd1;
        end else y1 <= y1 + 4'd1;
      end

      if (wr_en_i) begin
        case (wr_addr_i)
          4'h0: s1   <= wr_data_i;
          4'h1: s10  <= wr_data_i[2:0];
          4'h2: m1   <= wr_data_i;
          4'h3: m10  <= wr_data_i[2:0];
          4'h4: h1   <= wr_data_i;
          4'h5: begin
            h10 <= wr_data_i[1:0];
            if (!mode24_i) pm <= wr_data_i[2];
          end
          4'h6: d1   <= wr_data_i;
          4'h7: d10  <= wr_data_i[1:0];
          4'h8: mo1  <= wr_data_i;
          4'h9: mo10 <= wr_data_i[0];
          4'hA: y1   <= wr_data_i;
          4'hB: y10  <= wr_data_i;
          4'hC: wd   <= wr_data_i[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr_i)
      4'h0: rd_data_o = s1;
      4'h1: rd_data_o = {1'b0, s10};
      4'h2: rd_data_o = m1;
      4'h3: rd_data_o = {1'b0, m10};
      4'h4: rd_data_o = h1;
      4'h5: rd_data_o = {1'b0, pm && !mode24_i, h10};
      4'h6: rd_data_o = d1;
      4'h7: rd_data_o = {2'b0, d10};
      4'h8: rd_data_o = mo1;
      4'h9: rd_data_o = {3'b0, mo10};
      4'hA: rd_data_o = y1;
      4'hB: rd_data_o = y10;
      4'hC: rd_data_o = {1'b0, wd};
      default: rd_data_o = 4'h0;
    endcase
  end

  assign adj_busy_o   = busy;
  assign sec_carry_o  = sec_q;
  assign min_carry_o  = min_q;
  assign hour_carry_o = hr_q;
endmodule

module bcd_calendar_chk #(
  parameter int ADJ_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_i,
  input logic       wr_en_i,
  input logic       adj_req_i,
  input logic       adj_busy_o,
  input logic       sec_carry_o,
  input logic       min_carry_o,
  input logic       hour_carry_o,
  input logic [3:0] s1,
  input logic [2:0] s10
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= 0;
    else if (adj_busy_o) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  // R12
  hour_with_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hour_carry_o |-> min_carry_o);

  // R12
  min_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    min_carry_o |-> (sec_carry_o || $past(adj_busy_o)));

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !wr_en_i && !adj_busy_o) |=> $stable({s10, s1}));

  // R10
  hold_no_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !sec_carry_o);

  // R11
  adj_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adj_busy_o) |-> (busy_len == ADJ_CYCLES));

  // R11
  adj_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adj_busy_o) |-> $past(adj_req_i));
endmodule

bind bcd_calendar bcd_calendar_chk #(.ADJ_CYCLES(ADJ_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .wr_en_i(wr_en_i),
  .adj_req_i(adj_req_i), .adj_busy_o(adj_busy_o), .sec_carry_o(sec_carry_o),
  .min_carry_o(min_carry_o), .hour_carry_o(hour_carry_o), .s1(s1), .s10(s10)
);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  localparam int CLK_P = 10;
  localparam int ADJ   = 4;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode24 = 1'b1, tick = 1'b0, hold = 1'b0, adj_req = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [3:0] rd_data;
  logic busy, sec_c, min_c, hr_c;

  int nchk = 0, nfail = 0;
  int ms, mm, mh, md, mmo, my, mw;

  always #(CLK_P/2) clk = ~clk;

  bcd_calendar #(.ADJ_CYCLES(ADJ)) dut (
    .clk(clk), .rst_n(rst_n), .mode24_i(mode24), .tick_i(tick), .hold_i(hold),
    .adj_req_i(adj_req), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .adj_busy_o(busy),
    .sec_carry_o(sec_c), .min_carry_o(min_c), .hour_carry_o(hr_c)
  );

  function automatic int dim_f(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [3:0] exp_reg(input int a);
    int h, v;
    h = mode24 ? mh : ((mh % 12 == 0) ? 12 : mh % 12);
    case (a)
      0: v = ms % 10;   1: v = ms / 10;
      2: v = mm % 10;   3: v = mm / 10;
      4: v = h % 10;
      5: v = h / 10 + ((!mode24 && mh >= 12) ? 4 : 0);
      6: v = md % 10;   7: v = md / 10;
      8: v = mmo % 10;  9: v = mmo / 10;
      10: v = my % 10;  11: v = my / 10;
      12: v = mw;
      default: v = 0;
    endcase
    return 4'(v);
  endfunction

  function automatic logic [3:0] mask_f(input int a);
    case (a)
      1, 3, 12: return 4'h7;
      5: return mode24 ? 4'h3 : 4'h7;
      7: return 4'h3;
      9: return 4'h1;
      13, 14, 15: return 4'h0;
      default: return 4'hF;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [3:0] got, input logic [3:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 13; a++) begin
      rd_addr = 4'(a);
      #1;
      chk(req, $sformatf("digit %0d", a), rd_data, exp_reg(a));
    end
  endtask

  task automatic wr(input int a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load();
    for (int a = 0; a < 13; a++) wr(a, exp_reg(a));
  endtask

  task automatic madv_min();
    mm++;
    if (mm == 60) begin
      mm = 0; mh++;
      if (mh == 24) begin
        mh = 0; mw = (mw + 1) % 7;
        if (md >= dim_f(mmo, my)) begin
          md = 1; mmo++;
          if (mmo > 12) begin mmo = 1; my = (my + 1) % 100; end
        end else md++;
      end
    end
  endtask

  task automatic tick1(input string req);
    logic em, eh;
    em = (ms == 59);
    eh = em && (mm == 59);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    ms++;
    if (ms == 60) begin ms = 0; madv_min(); end
    chk("R12", "sec strobe", {3'b0, sec_c}, 4'h1);
    chk("R12", "min strobe", {3'b0, min_c}, {3'b0, em});
    chk("R12", "hour strobe", {3'b0, hr_c}, {3'b0, eh});
    check_all(req);
  endtask

  task automatic set_model(input int h, input int mi, input int s, input int d,
                           input int mo, input int y, input int w);
    mh = h; mm = mi; ms = s; md = d; mmo = mo; my = y; mw = w;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    set_model(0, 0, 0, 1, 1, 0, 0);
    check_all("R1");
    chk("R1", "busy", {3'b0, busy}, 4'h0);
    chk("R1", "strobes", {1'b0, sec_c, min_c, hr_c}, 4'h0);

    // R2 R3 R7: an hour across a year rollover in 24-hour mode
    set_model(23, 0, 0, 31, 12, 99, 6);
    load();
    for (int i = 0; i < 3700; i++) tick1("R2 R3 R7");

    // R4 R3: every hour boundary in both modes
    for (int md24 = 0; md24 < 2; md24++) begin
      for (int h = 0; h < 24; h++) begin
        mode24 = md24[0];
        set_model(h, 59, 58, 28, 2, 23, 5);
        load();
        for (int k = 0; k < 3; k++) tick1("R4 R3");
      end
    end
    mode24 = 1'b1;

    // R5 R6 R7: last days of every month of every year, incl. invalid dates
    for (int y = 0; y < 100; y++)
      for (int mo = 1; mo < 13; mo++)
        for (int d = 28; d < 32; d++) begin
          set_model(23, 59, 59, d, mo, y, 3);
          load();
          tick1("R5 R6");
        end

    // R11: rounding adjust for every seconds value
    for (int s = 0; s < 60; s++) begin
      logic ok, up;
      set_model(23, 59, s, 31, 12, 99, 6);
      load();
      adj_req = 1'b1;
      @(negedge clk);
      adj_req = 1'b0;
      ok = 1'b1;
      for (int i = 0; i < ADJ; i++) begin
        if (busy !== 1'b1) ok = 1'b0;
        adj_req = (i == 1);
        @(negedge clk);
      end
      adj_req = 1'b0;
      up = (s >= 30);
      ms = 0;
      if (up) madv_min();
      chk("R11", "busy window", {3'b0, ok}, 4'h1);
      chk("R11", "busy end", {3'b0, busy}, 4'h0);
      chk("R11", "min strobe", {3'b0, min_c}, {3'b0, up});
      chk("R11", "sec strobe", {3'b0, sec_c}, 4'h0);
      check_all("R11");
    end

    // R10: hold with pending ticks
    set_model(10, 20, 30, 15, 6, 44, 2);
    load();
    hold = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      chk("R10", "sec strobe in hold", {3'b0, sec_c}, 4'h0);
      check_all("R10");
    end
    hold = 1'b0;
    @(negedge clk);
    ms++;
    chk("R10", "release strobe", {3'b0, sec_c}, 4'h1);
    check_all("R10");
    @(negedge clk);
    chk("R10", "single add", {3'b0, sec_c}, 4'h0);
    check_all("R10");

    // R8: nonexistent bits, 12-hour mode
    mode24 = 1'b0;
    for (int a = 0; a < 16; a++) begin
      wr(a, 4'hF);
      rd_addr = 4'(a);
      #1;
      chk("R8", $sformatf("mask addr %0d", a), rd_data, mask_f(a));
    end

    // R9 R4: PM flag in both modes
    wr(5, 4'h5);
    rd_addr = 4'h5; #1;
    chk("R4", "pm write 12h", rd_data, 4'h5);
    mode24 = 1'b1; #1;
    chk("R9", "pm hidden 24h", rd_data, 4'h1);
    wr(5, 4'h4);
    rd_addr = 4'h5; #1;
    chk("R9", "pm write ignored", rd_data, 4'h0);
    mode24 = 1'b0; #1;
    chk("R9", "pm kept", rd_data, 4'h4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule